// File: doc/BRIEF.md
# Word Memory Bus Decoder

This block sits between a CPU port that addresses 16-bit words and two kinds of target. The first is a local RAM with a one-cycle registered read. The second is a window of memory-mapped device slots. For each request the block adds a base and an offset to form an effective word address. It then drives either the RAM strobe or a device-select strobe that carries a 12-bit slot number. A per-slot claim bitmap tells the decoder which slots have a device behind them. An access to a slot with no claim ends with a bus error and zero data.

The CPU can also ask for a single byte. For a byte access the offset counts bytes, so the word address is the base plus half the offset. The low bit of the offset selects the byte lane within the word. A byte read returns the chosen lane, zero-extended. A byte write reads the containing word, replaces one lane and writes the whole word back. A byte write aimed at the top page of the address space is refused. One configuration input moves a word read at the second-highest word address back onto RAM.

The CPU uses a request/done handshake. A request is taken only while the block is idle. Each access ends with a single-cycle done strobe, and the result data and any error are valid with it.

Top module: `word_bus_decoder`

## Requirements
- R1: The effective word address of a word access is (cpu_base + cpu_ofs) mod 2^16. This address appears on mem_addr for RAM accesses, and its low 12 bits appear on dev_slot for device accesses.
- R2: An effective address below 0xF000 drives only mem_en. An address of 0xF000 or above drives only dev_sel, with dev_slot = address[11:0]. mem_en and dev_sel are never high in the same cycle, and a RAM write never targets an address of 0xF000 or above.
- R3: If the addressed slot's bit in dev_claim is 0, a device read or write ends with cpu_berr = 1 together with cpu_done, and cpu_rdata = 0x0000. If the bit is 1, a device read returns dev_rdata with cpu_berr = 0.
- R4: When big_mem = 1, a read whose word address is 0xFFFE goes to RAM and not to slot 0xFFE. When big_mem = 0, the same read goes to slot 0xFFE.
- R5: When cpu_byte = 1, the word address is cpu_base + (cpu_ofs >> 1). cpu_ofs[0] = 1 selects bits [15:8] and cpu_ofs[0] = 0 selects bits [7:0]. A byte read returns the selected lane zero-extended to 16 bits.
- R6: A byte write to RAM reads the containing word first. It then writes that word back with only the selected lane replaced by cpu_wdata[7:0]. The other lane and cpu_wdata[15:8] have no effect.
- R7: A byte write whose word address is 0xFC00 or above ends one cycle after acceptance with cpu_done and cpu_berr = 1. It raises neither mem_en nor dev_sel, and memory and devices stay unchanged.
- R8: Counted from the clock edge that accepts the request, cpu_done appears after a set number of further edges: reject 0, RAM word write 1, device access 1, RAM read 2, device byte write 2, RAM byte write 3. cpu_done lasts one cycle, and a request raised while an access is in flight is ignored.
- R9: After reset, cpu_done, cpu_berr, mem_en and dev_sel are 0 and cpu_rdata is 0x0000.
- R10: A byte write whose word address lies in 0xF000..0xFBFF reads the claimed slot and writes back the merged word to that slot. If the slot is unclaimed, the write ends with a bus error and no device write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_byte | input | 1 | 1 = byte access, offset counts bytes |
| cpu_we | input | 1 | 1 = write |
| cpu_base | input | 16 | Base word address |
| cpu_ofs | input | 16 | Word or byte offset |
| cpu_wdata | input | 16 | Write data (byte writes use [7:0]) |
| big_mem | input | 1 | Large-memory flag for reads at 0xFFFE |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_berr | output | 1 | Bus error, valid with cpu_done |
| cpu_rdata | output | 16 | Read result, valid with cpu_done |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after mem_en |
| dev_sel | output | 1 | Device slot access strobe |
| dev_we | output | 1 | Device write enable |
| dev_slot | output | 12 | Device slot index |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, same cycle as dev_sel |
| dev_claim | input | 4096 | Per-slot claim bitmap |

## Verification
The bench probes the edges of the address map.

- An offset that wraps past 0xFFFF must land at a low address. A design that carries into a 17th bit would fetch the wrong word.
- Word address 0xFFFE is read with big_mem both set and clear. A decoder that ignores the flag returns device data where RAM data is due.
- 0xFBFF and 0xFC00 are hit by byte writes. An off-by-one limit either corrupts the top page or refuses a legal device write.
- Byte writes go to each lane, with junk in cpu_wdata[15:8]. A merge with its lanes swapped, or one that writes whole words, leaves a wrong word in RAM.
- Completion latencies and ignored mid-flight requests are counted at the ports. A design with a missing wait state, or one that accepts a second request, shows up as a wrong cycle count or an extra RAM strobe.

// File: rtl/wbd_pkg.sv
package wbd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAM_WAIT,
        ST_RAM_CAP,
        ST_DEV_CHK,
        ST_WR_END
    } wbd_state_e;

    typedef enum logic [1:0] {
        TGT_RAM,
        TGT_DEV,
        TGT_REJECT
    } wbd_target_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/wbd_addr_gen.sv
module wbd_addr_gen
    import wbd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LANE_W    = 1,
    parameter logic [ADDR_W-1:0] DEV_BASE  = 16'hF000,
    parameter logic [ADDR_W-1:0] BYTE_LIM  = 16'hFC00,
    parameter logic [ADDR_W-1:0] BIG_ADDR  = 16'hFFFE
) (
    input  logic              is_byte,
    input  logic              is_write,
    input  logic              big_mem,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [LANE_W-1:0] lane,
    output wbd_target_e       target
);
    logic [ADDR_W-1:0] scaled_ofs;
    logic              big_hit;

    always_comb begin
        scaled_ofs = is_byte ? (ofs >> LANE_W) : ofs;
        eff_addr   = base + scaled_ofs;
        lane       = is_byte ? ofs[LANE_W-1:0] : '0;
        big_hit    = big_mem && !is_write && (eff_addr == BIG_ADDR);
        if (is_byte && is_write && (eff_addr >= BYTE_LIM)) begin
            target = TGT_REJECT;
        end else if ((eff_addr < DEV_BASE) || big_hit) begin
            target = TGT_RAM;
        end else begin
            target = TGT_DEV;
        end
    end

endmodule

// File: rtl/wbd_lane_merge.sv
module wbd_lane_merge
    import wbd_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 1
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] extracted
);
    localparam int unsigned LANES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] picked [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(g)) ? byte_in : word_in[g*BYTE_W +: BYTE_W];
        assign picked[g] = word_in[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        extracted = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i)) begin
                extracted[BYTE_W-1:0] = picked[i];
            end
        end
    end

endmodule

// File: rtl/wbd_ctrl.sv
module wbd_ctrl
    import wbd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 1,
    parameter logic [ADDR_W-1:0] DEV_BASE = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_byte,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [LANE_W-1:0] lane,
    input  wbd_target_e       target,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              slot_claimed,
    output logic              done,
    output logic              berr,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic              dev_sel,
    output logic              dev_we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] out_wdata
);
    typedef struct packed {
        wbd_state_e        state;
        logic              mem_en;
        logic              mem_we;
        logic              dev_sel;
        logic              dev_we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              is_byte;
        logic              is_write;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] bdata;
        logic              done;
        logic              berr;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] merged_word;
    logic [DATA_W-1:0] lane_word;
    logic              byte_wr;

    assign src_word = (r_q.state == ST_DEV_CHK) ? dev_rdata : mem_rdata;
    assign byte_wr  = r_q.is_byte && r_q.is_write;

    wbd_lane_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .word_in   (src_word),
        .lane      (r_q.lane),
        .byte_in   (r_q.bdata),
        .merged    (merged_word),
        .extracted (lane_word)
    );

    always_comb begin
        r_d         = r_q;
        r_d.mem_en  = 1'b0;
        r_d.dev_sel = 1'b0;
        r_d.done    = 1'b0;
        r_d.berr    = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr     = eff_addr;
                    r_d.wdata    = wdata;
                    r_d.is_byte  = is_byte;
                    r_d.is_write = is_write;
                    r_d.lane     = lane;
                    r_d.bdata    = wdata[BYTE_W-1:0];
                    case (target)
                        TGT_REJECT: begin
                            r_d.done  = 1'b1;
                            r_d.berr  = 1'b1;
                            r_d.rdata = '0;
                        end
                        TGT_RAM: begin
                            r_d.mem_en = 1'b1;
                            r_d.mem_we = is_write && !is_byte;
                            r_d.state  = (is_write && !is_byte) ? ST_WR_END : ST_RAM_WAIT;
                        end
                        default: begin
                            r_d.dev_sel = 1'b1;
                            r_d.dev_we  = is_write && !is_byte;
                            r_d.state   = ST_DEV_CHK;
                        end
                    endcase
                end
            end
            ST_RAM_WAIT: begin
                r_d.state = ST_RAM_CAP;
            end
            ST_RAM_CAP: begin
                if (byte_wr) begin
                    r_d.mem_en = 1'b1;
                    r_d.mem_we = 1'b1;
                    r_d.wdata  = merged_word;
                    r_d.state  = ST_WR_END;
                end else begin
                    r_d.done  = 1'b1;
                    r_d.rdata = r_q.is_byte ? lane_word : src_word;
                    r_d.state = ST_IDLE;
                end
            end
            ST_DEV_CHK: begin
                if (!slot_claimed) begin
                    r_d.done  = 1'b1;
                    r_d.berr  = 1'b1;
                    r_d.rdata = '0;
                    r_d.state = ST_IDLE;
                end else if (byte_wr) begin
                    r_d.dev_sel = 1'b1;
                    r_d.dev_we  = 1'b1;
                    r_d.wdata   = merged_word;
                    r_d.state   = ST_WR_END;
                end else begin
                    r_d.done  = 1'b1;
                    r_d.rdata = r_q.is_write ? '0 :
                                (r_q.is_byte ? lane_word : src_word);
                    r_d.state = ST_IDLE;
                end
            end
            ST_WR_END: begin
                r_d.done  = 1'b1;
                r_d.rdata = '0;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign berr      = r_q.berr;
    assign rdata     = r_q.rdata;
    assign mem_en    = r_q.mem_en;
    assign mem_we    = r_q.mem_we;
    assign dev_sel   = r_q.dev_sel;
    assign dev_we    = r_q.dev_we;
    assign addr      = r_q.addr;
    assign out_wdata = r_q.wdata;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && dev_sel));

    // R2
    ram_write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (addr < DEV_BASE));

    // R6
    rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && r_q.is_byte) |-> ($past(mem_en, 2) && !$past(mem_we, 2)));

    // R7
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && req && target == TGT_REJECT)
            |=> (done && berr && !mem_en && !dev_sel));

    // R8
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(req) || $past(r_q.state != ST_IDLE)));

    // R3
    berr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (done && rdata == '0));

endmodule

// File: rtl/word_bus_decoder.sv
module word_bus_decoder
    import wbd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SLOT_W   = 12,
    parameter logic [ADDR_W-1:0] DEV_BASE = 16'hF000,
    parameter logic [ADDR_W-1:0] BYTE_LIM = 16'hFC00,
    parameter logic [ADDR_W-1:0] BIG_ADDR = 16'hFFFE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_byte,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_base,
    input  logic [ADDR_W-1:0]       cpu_ofs,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    big_mem,
    output logic                    cpu_done,
    output logic                    cpu_berr,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    dev_sel,
    output logic                    dev_we,
    output logic [SLOT_W-1:0]       dev_slot,
    output logic [DATA_W-1:0]       dev_wdata,
    input  logic [DATA_W-1:0]       dev_rdata,
    input  logic [(1<<SLOT_W)-1:0]  dev_claim
);
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [ADDR_W-1:0] eff_addr;
    logic [LANE_W-1:0] lane;
    wbd_target_e       target;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic              slot_claimed;

    wbd_addr_gen #(
        .ADDR_W   (ADDR_W),
        .LANE_W   (LANE_W),
        .DEV_BASE (DEV_BASE),
        .BYTE_LIM (BYTE_LIM),
        .BIG_ADDR (BIG_ADDR)
    ) u_addr (
        .is_byte  (cpu_byte),
        .is_write (cpu_we),
        .big_mem  (big_mem),
        .base     (cpu_base),
        .ofs      (cpu_ofs),
        .eff_addr (eff_addr),
        .lane     (lane),
        .target   (target)
    );

    assign slot_claimed = dev_claim[held_addr[SLOT_W-1:0]];

    wbd_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LANE_W   (LANE_W),
        .DEV_BASE (DEV_BASE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cpu_req),
        .is_byte      (cpu_byte),
        .is_write     (cpu_we),
        .wdata        (cpu_wdata),
        .eff_addr     (eff_addr),
        .lane         (lane),
        .target       (target),
        .mem_rdata    (mem_rdata),
        .dev_rdata    (dev_rdata),
        .slot_claimed (slot_claimed),
        .done         (cpu_done),
        .berr         (cpu_berr),
        .rdata        (cpu_rdata),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .dev_sel      (dev_sel),
        .dev_we       (dev_we),
        .addr         (held_addr),
        .out_wdata    (held_wdata)
    );

    assign mem_addr  = held_addr;
    assign mem_wdata = held_wdata;
    assign dev_slot  = held_addr[SLOT_W-1:0];
    assign dev_wdata = held_wdata;

endmodule

// File: tb/word_bus_decoder_bench.sv
module word_bus_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_byte = 1'b0, cpu_we = 1'b0, big_mem = 1'b0;
    logic [15:0] cpu_base = '0, cpu_ofs = '0, cpu_wdata = '0;
    logic        cpu_done, cpu_berr, mem_en, mem_we, dev_sel, dev_we;
    logic [15:0] cpu_rdata, mem_addr, mem_wdata, dev_wdata, dev_rdata;
    logic [15:0] mem_rdata = '0;
    logic [11:0] dev_slot;
    logic [4095:0] dev_claim = '0;

    int checks = 0;
    int fails  = 0;
    int mem_strobes = 0;
    int dev_writes  = 0;
    logic [11:0] last_dev_slot = '0;
    logic [15:0] last_dev_data = '0;
    logic [15:0] ram [4096];

    always #2.5 clk = ~clk;

    word_bus_decoder u_word_bus_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_byte(cpu_byte),
        .cpu_we(cpu_we), .cpu_base(cpu_base), .cpu_ofs(cpu_ofs),
        .cpu_wdata(cpu_wdata), .big_mem(big_mem), .cpu_done(cpu_done),
        .cpu_berr(cpu_berr), .cpu_rdata(cpu_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_we(dev_we),
        .dev_slot(dev_slot), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_claim(dev_claim)
    );

    // RAM model: 4096 words, indexed by the low 12 address bits, registered read
    always @(posedge clk) begin
        if (mem_en) begin
            mem_strobes <= mem_strobes + 1;
            if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
            mem_rdata <= ram[mem_addr[11:0]];
        end
        if (dev_sel && dev_we) begin
            dev_writes    <= dev_writes + 1;
            last_dev_slot <= dev_slot;
            last_dev_data <= dev_wdata;
        end
    end

    // device model: read data is 0xA in the top nibble and the slot number below
    assign dev_rdata = (dev_sel && !dev_we) ? {4'hA, dev_slot} : 16'h0000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic b, input logic w, input logic [15:0] base,
                          input logic [15:0] ofs, input logic [15:0] wd, input logic big,
                          output logic [15:0] rd, output logic err, output int n);
        @(negedge clk);
        cpu_req = 1'b1; cpu_byte = b; cpu_we = w; cpu_base = base;
        cpu_ofs = ofs; cpu_wdata = wd; big_mem = big;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 1;
        while (!cpu_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        rd = cpu_rdata;
        err = cpu_berr;
    endtask

    typedef struct packed {
        logic        is_byte;
        logic        big;
        logic [15:0] base;
        logic [15:0] ofs;
        logic [15:0] exp_rd;
        logic        exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0100, 16'h0023, 16'h5123, 1'b0},   // R1 R2 RAM word
        '{1'b0, 1'b0, 16'hFFFF, 16'h0002, 16'h5001, 1'b0},   // R1 wraps
        '{1'b0, 1'b0, 16'hF000, 16'h0010, 16'hA010, 1'b0},   // R2 R3 claimed slot
        '{1'b0, 1'b0, 16'hF000, 16'h0011, 16'h0000, 1'b1},   // R3 unclaimed
        '{1'b0, 1'b1, 16'hFFF0, 16'h000E, 16'h5FFE, 1'b0},   // R4 big on -> RAM
        '{1'b0, 1'b0, 16'hFFF0, 16'h000E, 16'hAFFE, 1'b0},   // R4 big off -> slot
        '{1'b1, 1'b0, 16'h0200, 16'h0007, 16'h0052, 1'b0},   // R5 high lane
        '{1'b1, 1'b0, 16'h0200, 16'h0006, 16'h0003, 1'b0},   // R5 low lane
        '{1'b1, 1'b0, 16'hF000, 16'h0021, 16'h00A0, 1'b0}    // R5 device byte
    };

    logic [15:0] rd;
    logic        err;
    int          n;
    int          s0, w0;

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = {4'h5, 12'(i)};
        dev_claim[12'h010] = 1'b1;
        dev_claim[12'hFFE] = 1'b1;
        dev_claim[12'hBFF] = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 done", {31'd0, cpu_done}, 0);
        check("R9 berr", {31'd0, cpu_berr}, 0);
        check("R9 strobes", {30'd0, mem_en, dev_sel}, 0);
        check("R9 rdata", {16'd0, cpu_rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].is_byte, 1'b0, VECS[v].base, VECS[v].ofs, 16'h0,
                   VECS[v].big, rd, err, n);
            check($sformatf("R1 R2 R3 R4 R5 vector %0d rdata", v), {16'd0, rd}, {16'd0, VECS[v].exp_rd});
            check($sformatf("R3 vector %0d berr", v), {31'd0, err}, {31'd0, VECS[v].exp_err});
        end

        // R2 R8 RAM word write then read back
        access(1'b0, 1'b1, 16'h0300, 16'h0000, 16'h1234, 1'b0, rd, err, n);
        check("R8 RAM word write latency", n, 2);
        access(1'b0, 1'b0, 16'h0300, 16'h0000, 16'h0, 1'b0, rd, err, n);
        check("R2 word readback", {16'd0, rd}, 32'h1234);
        check("R8 RAM read latency", n, 3);
        @(negedge clk);
        check("R8 done one cycle", {31'd0, cpu_done}, 0);

        // R6 byte writes, high lane then low lane with junk upper byte
        access(1'b1, 1'b1, 16'h0300, 16'h0001, 16'h00CD, 1'b0, rd, err, n);
        check("R8 RAM byte write latency", n, 4);
        access(1'b0, 1'b0, 16'h0300, 16'h0000, 16'h0, 1'b0, rd, err, n);
        check("R6 high lane merge", {16'd0, rd}, 32'hCD34);
        access(1'b1, 1'b1, 16'h0300, 16'h0000, 16'h77EF, 1'b0, rd, err, n);
        access(1'b0, 1'b0, 16'h0300, 16'h0000, 16'h0, 1'b0, rd, err, n);
        check("R6 low lane merge", {16'd0, rd}, 32'hCDEF);

        // R7 reject at the 0xFC00 boundary
        s0 = mem_strobes; w0 = dev_writes;
        access(1'b1, 1'b1, 16'hFBFF, 16'h0002, 16'h0099, 1'b0, rd, err, n);
        check("R7 reject berr", {31'd0, err}, 1);
        check("R7 reject latency", n, 1);
        check("R7 no RAM strobe", mem_strobes, s0);
        check("R7 no device write", dev_writes, w0);
        access(1'b0, 1'b0, 16'h0C00, 16'h0000, 16'h0, 1'b0, rd, err, n);
        check("R7 memory unchanged", {16'd0, rd}, 32'h5C00);

        // R10 device byte write just below the boundary
        access(1'b1, 1'b1, 16'hFBFF, 16'h0000, 16'h0011, 1'b0, rd, err, n);
        check("R10 berr", {31'd0, err}, 0);
        check("R10 latency", n, 3);
        check("R10 slot", {20'd0, last_dev_slot}, 32'hBFF);
        check("R10 merged data", {16'd0, last_dev_data}, 32'hAB11);
        w0 = dev_writes;
        access(1'b1, 1'b1, 16'hF011, 16'h0001, 16'h0022, 1'b0, rd, err, n);
        check("R10 unclaimed berr", {31'd0, err}, 1);
        check("R10 unclaimed no write", dev_writes, w0);

        // R3 device word writes
        access(1'b0, 1'b1, 16'hF000, 16'h0010, 16'h4321, 1'b0, rd, err, n);
        check("R3 claimed write berr", {31'd0, err}, 0);
        check("R8 device latency", n, 2);
        check("R3 claimed write data", {16'd0, last_dev_data}, 32'h4321);
        access(1'b0, 1'b1, 16'hF000, 16'h0011, 16'h5555, 1'b0, rd, err, n);
        check("R3 unclaimed write berr", {31'd0, err}, 1);

        // R8 a request raised mid-flight is ignored
        s0 = mem_strobes;
        @(negedge clk);
        cpu_req = 1'b1; cpu_byte = 1'b0; cpu_we = 1'b0; big_mem = 1'b0;
        cpu_base = 16'h0100; cpu_ofs = 16'h0023;
        @(negedge clk);
        cpu_base = 16'h0400; cpu_ofs = 16'h0000;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        check("R8 first result kept", {16'd0, cpu_rdata}, 32'h5123);
        check("R8 done on time", {31'd0, cpu_done}, 1);
        repeat (4) @(negedge clk);
        check("R8 single RAM strobe", mem_strobes - s0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100us;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule